// File: doc/BRIEF.md
# Majority-Vote Late-Operand Predictor

This block keeps, per code block, a guess of which register-input instruction is the last to arrive and which register-output instruction is the last to leave before the block commits. A coordinator uses it when a block is fetched. It sends a lookup with the block PC and gets back two 7-bit instruction slot numbers, each with its own confidence flag. When a block commits, the core reports the observed last-arriving input and last-departing output. The table then trains both guesses with a streaming majority vote.

Each entry holds one tag and two independent tracks, one for inputs and one for outputs. Each track has a candidate slot and a saturating confidence counter. A matching observation raises the counter. A mismatch lowers it, and a mismatch at zero confidence makes the observation the new candidate. The table is direct-mapped. Its index is PC bits `[OFF_W +: IDX_W]` (bits 5:2 with defaults) and its tag is the PC bits above the index.

Top module: `crit_vote_pred`

## Requirements
- R1: After reset every entry is invalid, `rsp_vld_o` is low, and any lookup reports both tracks as not confident.
- R2: `rsp_vld_o` is high in exactly the cycle after a cycle in which `lk_req_i` was sampled high, and low otherwise.
- R3: A lookup whose index entry is invalid or carries a different tag reports `in_ok_o`=0 and `out_ok_o`=0.
- R4: A training request whose entry is invalid or tag-mismatched writes the new tag, sets each track's candidate to the observed slot and sets its counter to 1.
- R5: On a tag hit, an observation equal to the candidate increments that track's counter, saturating at 2^CW-1 (7 with CW=3).
- R6: On a tag hit, a mismatching observation decrements a nonzero counter and keeps the candidate; at counter zero it installs the observed slot as candidate with counter 1.
- R7: The input track is trained only by `tr_in_id_i` and the output track only by `tr_out_id_i`; neither affects the other.
- R8: A track is reported confident (`*_ok_o`=1) only on a tag hit with counter >= THRESH (default 2); whenever a track's ok flag is 0 its id output is 0.
- R9: When a lookup and a training request in the same cycle map to the same index, the response reflects the entry after that training update.
- R10: A training miss replaces the resident entry at that index, so a later lookup with the old tag misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_req_i | input | 1 | Lookup request |
| lk_pc_i | input | PC_W | Block PC for lookup |
| tr_req_i | input | 1 | Training request |
| tr_pc_i | input | PC_W | Block PC for training |
| tr_in_id_i | input | 7 | Observed last-arriving input slot |
| tr_out_id_i | input | 7 | Observed last-departing output slot |
| rsp_vld_o | output | 1 | Lookup response valid |
| in_id_o | output | 7 | Predicted critical input slot (0 when not confident) |
| in_ok_o | output | 1 | Input prediction confident |
| out_id_o | output | 7 | Predicted critical output slot (0 when not confident) |
| out_ok_o | output | 1 | Output prediction confident |

## Verification
A lookup answer is registered once, so it is due one rising edge after the request is sampled. A training request changes the table at the same edge, and a lookup to that index in the same cycle already sees the change through the forwarding path. The bench drives every request on a falling edge, lets exactly one rising edge pass, and samples the response on the next falling edge. Each expected counter value is therefore tied to a known count of training edges. Saturation and replacement are checked by counting mismatches until the confidence flag drops at a precomputed step.

// File: rtl/crit_vote_pkg.sv
package crit_vote_pkg;
  parameter int unsigned ID_W  = 7;
  parameter int unsigned CNT_W = 3;
  parameter int unsigned NTRK  = 2;  // 0: input track, 1: output track

  typedef logic [ID_W-1:0]  inst_id_t;
  typedef logic [CNT_W-1:0] conf_t;

  typedef struct packed {
    inst_id_t id;
    conf_t    cnt;
  } track_t;
endpackage

// File: rtl/crit_vote_step.sv
module crit_vote_step
  import crit_vote_pkg::*;
(
  input  logic     hit_i,
  input  track_t   cur_i,
  input  inst_id_t obs_i,
  output track_t   nxt_o
);
  localparam conf_t CNT_MAX = '1;
  localparam conf_t CNT_ONE = conf_t'(1);

  always_comb begin
    nxt_o = cur_i;
    if (!hit_i) begin
      nxt_o.id  = obs_i;
      nxt_o.cnt = CNT_ONE;
    end else if (obs_i == cur_i.id) begin
      if (cur_i.cnt != CNT_MAX) nxt_o.cnt = cur_i.cnt + CNT_ONE;
    end else if (cur_i.cnt == '0) begin
      nxt_o.id  = obs_i;
      nxt_o.cnt = CNT_ONE;
    end else begin
      nxt_o.cnt = cur_i.cnt - CNT_ONE;
    end
  end
endmodule

// File: rtl/crit_vote_table.sv
module crit_vote_table
  import crit_vote_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 26,
  parameter int unsigned NRD   = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [IDX_W-1:0]                 wr_idx_i,
  input  logic [TAG_W-1:0]                 wr_tag_i,
  input  track_t [NTRK-1:0]                wr_trk_i,
  input  logic [NRD-1:0][IDX_W-1:0]        rd_idx_i,
  output logic [NRD-1:0]                   rd_vld_o,
  output logic [NRD-1:0][TAG_W-1:0]        rd_tag_o,
  output track_t [NRD-1:0][NTRK-1:0]       rd_trk_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]              vld_q;
  logic [TAG_W-1:0]              tag_q [DEPTH];
  track_t [NTRK-1:0]             trk_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (wr_en_i) vld_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      trk_q[wr_idx_i] <= wr_trk_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_vld_o[p] = vld_q[rd_idx_i[p]];
    assign rd_tag_o[p] = tag_q[rd_idx_i[p]];
    assign rd_trk_o[p] = trk_q[rd_idx_i[p]];
  end

  // R4: a training write leaves its entry valid
  assert_write_marks_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vld_q[$past(wr_idx_i)]);
endmodule

// File: rtl/crit_vote_pred.sv
module crit_vote_pred
  import crit_vote_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned THRESH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lk_req_i,
  input  logic [PC_W-1:0] lk_pc_i,
  input  logic            tr_req_i,
  input  logic [PC_W-1:0] tr_pc_i,
  input  logic [6:0]      tr_in_id_i,
  input  logic [6:0]      tr_out_id_i,
  output logic            rsp_vld_o,
  output logic [6:0]      in_id_o,
  output logic            in_ok_o,
  output logic [6:0]      out_id_o,
  output logic            out_ok_o
);
  localparam int unsigned TAG_W = PC_W - OFF_W - IDX_W;
  localparam int unsigned RD_TR = 0;
  localparam int unsigned RD_LK = 1;
  localparam conf_t       THR   = conf_t'(THRESH);

  logic [IDX_W-1:0] tr_idx, lk_idx;
  logic [TAG_W-1:0] tr_tag, lk_tag;

  assign tr_idx = tr_pc_i[OFF_W +: IDX_W];
  assign lk_idx = lk_pc_i[OFF_W +: IDX_W];
  assign tr_tag = tr_pc_i[PC_W-1 -: TAG_W];
  assign lk_tag = lk_pc_i[PC_W-1 -: TAG_W];

  logic [1:0][IDX_W-1:0]    rd_idx;
  logic [1:0]               rd_vld;
  logic [1:0][TAG_W-1:0]    rd_tag;
  track_t [1:0][NTRK-1:0]   rd_trk;
  track_t [NTRK-1:0]        new_trk;

  assign rd_idx[RD_TR] = tr_idx;
  assign rd_idx[RD_LK] = lk_idx;

  crit_vote_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .NRD(2)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (tr_req_i),
    .wr_idx_i (tr_idx),
    .wr_tag_i (tr_tag),
    .wr_trk_i (new_trk),
    .rd_idx_i (rd_idx),
    .rd_vld_o (rd_vld),
    .rd_tag_o (rd_tag),
    .rd_trk_o (rd_trk)
  );

  logic tr_hit;
  assign tr_hit = rd_vld[RD_TR] && (rd_tag[RD_TR] == tr_tag);

  inst_id_t [NTRK-1:0] obs;
  assign obs[0] = tr_in_id_i;
  assign obs[1] = tr_out_id_i;

  for (genvar g = 0; g < NTRK; g++) begin : g_step
    crit_vote_step u_step (
      .hit_i (tr_hit),
      .cur_i (rd_trk[RD_TR][g]),
      .obs_i (obs[g]),
      .nxt_o (new_trk[g])
    );
  end

  // Same-index training is applied before the lookup sees the entry.
  logic              fwd;
  logic              view_vld;
  logic [TAG_W-1:0]  view_tag;
  track_t [NTRK-1:0] view_trk;
  logic              lk_hit;

  assign fwd      = tr_req_i && (tr_idx == lk_idx);
  assign view_vld = fwd ? 1'b1    : rd_vld[RD_LK];
  assign view_tag = fwd ? tr_tag  : rd_tag[RD_LK];
  assign view_trk = fwd ? new_trk : rd_trk[RD_LK];
  assign lk_hit   = view_vld && (view_tag == lk_tag);

  logic                rsp_q;
  logic [NTRK-1:0]     ok_d, ok_q;
  inst_id_t [NTRK-1:0] id_d, id_q;

  for (genvar g = 0; g < NTRK; g++) begin : g_rsp
    assign ok_d[g] = lk_req_i && lk_hit && (view_trk[g].cnt >= THR);
    assign id_d[g] = ok_d[g] ? view_trk[g].id : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q <= 1'b0;
      ok_q  <= '0;
      id_q  <= '0;
    end else begin
      rsp_q <= lk_req_i;
      ok_q  <= ok_d;
      id_q  <= id_d;
    end
  end

  assign rsp_vld_o = rsp_q;
  assign in_ok_o   = ok_q[0];
  assign out_ok_o  = ok_q[1];
  assign in_id_o   = id_q[0];
  assign out_id_o  = id_q[1];

  // R2: response follows a request by one cycle
  assert_rsp_after_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> rsp_vld_o);
  assert_rsp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> !rsp_vld_o);
  // R8: confidence only with a response, ids zero when not confident
  assert_ok_needs_rsp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ok_o || out_ok_o) |-> rsp_vld_o);
  assert_in_id_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ok_o |-> (in_id_o == '0));
  assert_out_id_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_ok_o |-> (out_id_o == '0));
endmodule

// File: tb/sim_crit_vote_pred.sv
`timescale 1ns/1ps
module sim_crit_vote_pred;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_req_i = 1'b0;
  logic [31:0] lk_pc_i = '0;
  logic        tr_req_i = 1'b0;
  logic [31:0] tr_pc_i = '0;
  logic [6:0]  tr_in_id_i = '0;
  logic [6:0]  tr_out_id_i = '0;
  logic        rsp_vld_o, in_ok_o, out_ok_o;
  logic [6:0]  in_id_o, out_id_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  crit_vote_pred u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_req_i(lk_req_i), .lk_pc_i(lk_pc_i),
    .tr_req_i(tr_req_i), .tr_pc_i(tr_pc_i),
    .tr_in_id_i(tr_in_id_i), .tr_out_id_i(tr_out_id_i),
    .rsp_vld_o(rsp_vld_o), .in_id_o(in_id_o), .in_ok_o(in_ok_o),
    .out_id_o(out_id_o), .out_ok_o(out_ok_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, one rising edge, sample at next falling edge.
  task automatic step(input logic lk, input logic [31:0] lpc,
                      input logic tr, input logic [31:0] tpc,
                      input int iid, input int oid);
    lk_req_i = lk; lk_pc_i = lpc;
    tr_req_i = tr; tr_pc_i = tpc;
    tr_in_id_i = 7'(iid); tr_out_id_i = 7'(oid);
    @(posedge clk);
    @(negedge clk);
    lk_req_i = 1'b0; tr_req_i = 1'b0;
  endtask

  task automatic train(input logic [31:0] pc, input int iid, input int oid);
    step(1'b0, '0, 1'b1, pc, iid, oid);
  endtask

  task automatic expect_lk(input string req, input logic [31:0] pc,
                           input int iok, input int iid, input int ook, input int oid);
    step(1'b1, pc, 1'b0, '0, 0, 0);
    chk({req, " rsp_vld"}, rsp_vld_o, 1);
    chk({req, " in_ok"},   in_ok_o,   iok);
    chk({req, " in_id"},   in_id_o,   iid);
    chk({req, " out_ok"},  out_ok_o,  ook);
    chk({req, " out_id"},  out_id_o,  oid);
  endtask

  task automatic t_reset;
    chk("R1 rsp_vld after reset", rsp_vld_o, 0);
    expect_lk("R1 empty table", 32'h0000_1000, 0, 0, 0, 0);
    step(1'b0, '0, 1'b0, '0, 0, 0);
    chk("R2 no request no response", rsp_vld_o, 0);
  endtask

  task automatic t_alloc;
    train(32'h0000_1004, 5, 9);
    expect_lk("R4 alloc count one below threshold R8", 32'h0000_1004, 0, 0, 0, 0);
    train(32'h0000_1004, 5, 9);
    expect_lk("R8 count two confident", 32'h0000_1004, 1, 5, 1, 9);
    expect_lk("R3 tag alias misses", 32'h0000_2004, 0, 0, 0, 0);
  endtask

  task automatic t_replace;
    train(32'h0000_1008, 3, 11);
    train(32'h0000_1008, 4, 11);   // in: cnt 0 cand 3; out: cnt 2
    expect_lk("R6 decrement to zero, R7 out independent", 32'h0000_1008, 0, 0, 1, 11);
    train(32'h0000_1008, 4, 11);   // in: cand 4 cnt 1
    expect_lk("R6 new candidate count one", 32'h0000_1008, 0, 0, 1, 11);
    train(32'h0000_1008, 4, 11);   // in: cnt 2
    expect_lk("R6 new candidate confident", 32'h0000_1008, 1, 4, 1, 11);
  endtask

  task automatic t_sat;
    for (int i = 0; i < 10; i++) train(32'h0000_100C, 20, 30); // in cnt 7
    for (int i = 0; i < 5; i++) train(32'h0000_100C, 21, 30);  // in cnt 2
    expect_lk("R5 saturated then five misses", 32'h0000_100C, 1, 20, 1, 30);
    train(32'h0000_100C, 21, 30);                               // in cnt 1
    expect_lk("R5 sixth miss drops confidence", 32'h0000_100C, 0, 0, 1, 30);
  endtask

  task automatic t_same_cycle;
    train(32'h0000_1010, 7, 8);
    step(1'b1, 32'h0000_1010, 1'b1, 32'h0000_1010, 7, 8);
    chk("R9 same cycle rsp", rsp_vld_o, 1);
    chk("R9 same cycle in_ok", in_ok_o, 1);
    chk("R9 same cycle in_id", in_id_o, 7);
    chk("R9 same cycle out_id", out_id_o, 8);
  endtask

  task automatic t_evict;
    train(32'h0000_2004, 12, 13);
    expect_lk("R10 old tag evicted", 32'h0000_1004, 0, 0, 0, 0);
    expect_lk("R10 new tag count one", 32'h0000_2004, 0, 0, 0, 0);
    train(32'h0000_2004, 12, 13);
    expect_lk("R10 new tag confident", 32'h0000_2004, 1, 12, 1, 13);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        t_reset();
        t_alloc();
        t_replace();
        t_sat();
        t_same_cycle();
        t_evict();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule